// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block executes the memory-access group of a 16-bit, word-addressed processor. Given an instruction word and the already-incremented program counter, it forms an effective address in one of three ways: PC plus a 9-bit signed offset, a pointer fetched from the PC-relative location, or a base register plus a 6-bit signed offset. It then issues the matching data read or write on a request/ready memory port.

Loaded values are returned through a register write-back port and update a three-bit sign flag register. An address-only instruction writes the computed address straight to a register and never touches memory. A one-cycle done pulse marks the end of every accepted instruction. Fetch, branching and the rest of the pipeline sit outside the block. The register file is read combinationally through two read ports driven from the latched instruction.

Top module: `ls_agen`

## Requirements
- R1: While reset is held and right after it is released, mem_req_o, rf_we_o and done_o are 0 and flags_o is 3'b010 (N,Z,P order, Z set).
- R2: Opcode 4'b0010 (direct load) reads address npc_i + sign-extended instr[8:0]. The word returned is written to the register named by instr[11:9]. With no wait states, done_o is seen three cycles after start_i is sampled.
- R3: Opcode 4'b0110 (base load) reads address base register instr[8:6] + sign-extended instr[5:0], and writes the word to register instr[11:9].
- R4: Opcode 4'b1010 (indirect load) first reads a pointer at npc_i + sign-extended instr[8:0], then reads the word at that pointer and writes it to register instr[11:9]. Both accesses are reads.
- R5: Opcodes 4'b0011 (direct store) and 4'b0111 (base store) write register instr[11:9] to the address formed as in R2 and R3. They perform no register write and leave flags_o unchanged.
- R6: Opcode 4'b1011 (indirect store) reads a pointer at npc_i + sign-extended instr[8:0], then writes register instr[11:9] to the pointed-to address.
- R7: Opcode 4'b1110 (address only) writes npc_i + sign-extended instr[8:0] to register instr[11:9], makes no memory request, leaves flags_o unchanged, and shows done_o two cycles after start.
- R8: After a load, flags_o is 3'b100 when bit 15 of the loaded word is 1, 3'b010 when the word is zero, and 3'b001 otherwise. Exactly one flag is ever set.
- R9: While mem_req_o is 1 and mem_ready_i is 0, mem_addr_o, mem_we_o and mem_wdata_o keep their values.
- R10: start_i is ignored while an instruction is in progress. Any opcode outside R2-R7's set produces done_o two cycles after start, with no memory request and no register write.
- R11: done_o is a single-cycle pulse, given once per accepted instruction. For loads it coincides with rf_we_o.
- R12: Address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin executing instr_i (sampled when idle) |
| instr_i | input | 16 | Instruction word |
| npc_i | input | 16 | Incremented program counter |
| base_raddr_o | output | 3 | Register file read index for the base register |
| base_rdata_i | input | 16 | Base register value |
| src_raddr_o | output | 3 | Register file read index for store data |
| src_rdata_i | input | 16 | Store data register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid with mem_ready_i |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 3 | Register write index |
| rf_wdata_o | output | 16 | Register write data |
| flags_o | output | 3 | Sign flags {N,Z,P} |
| done_o | output | 1 | Instruction finished pulse |

## Verification
The hardest case to reach is the indirect store. In it the read of the pointer redirects a later write, and both accesses stretch over wait states, so the request must stay up while the address and the direction change between the two phases. The bench memory model inserts a programmable number of wait cycles before each ready. On every wait cycle it compares the address, direction and data with what was first presented. It logs each access in order, so the pointer read and the redirected write can be told apart. A second start pulse is also held during a running load, to show that it leaves no trace.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ILEN       = 16;
  localparam int OPC_W      = 4;
  localparam int OFF_PC_W   = 9;
  localparam int OFF_BASE_W = 6;
  localparam int DR_LSB     = 9;
  localparam int BASE_LSB   = 6;

  localparam logic [OPC_W-1:0] OP_LD  = 4'b0010;
  localparam logic [OPC_W-1:0] OP_LDI = 4'b1010;
  localparam logic [OPC_W-1:0] OP_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OP_LEA = 4'b1110;
  localparam logic [OPC_W-1:0] OP_ST  = 4'b0011;
  localparam logic [OPC_W-1:0] OP_STI = 4'b1011;
  localparam logic [OPC_W-1:0] OP_STR = 4'b0111;

  typedef enum logic [1:0] {K_NONE, K_LOAD, K_STORE, K_ADDR} kind_e;
  typedef enum logic [1:0] {AM_PC, AM_IND, AM_BASE} amode_e;
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_PTR, S_MEM} state_e;

  typedef struct packed {
    kind_e  kind;
    amode_e amode;
  } dec_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '{kind: K_NONE, amode: AM_PC};
    unique case (opc_i)
      OP_LD:   dec_o = '{kind: K_LOAD,  amode: AM_PC};
      OP_LDI:  dec_o = '{kind: K_LOAD,  amode: AM_IND};
      OP_LDR:  dec_o = '{kind: K_LOAD,  amode: AM_BASE};
      OP_ST:   dec_o = '{kind: K_STORE, amode: AM_PC};
      OP_STI:  dec_o = '{kind: K_STORE, amode: AM_IND};
      OP_STR:  dec_o = '{kind: K_STORE, amode: AM_BASE};
      OP_LEA:  dec_o = '{kind: K_ADDR,  amode: AM_PC};
      default: dec_o = '{kind: K_NONE,  amode: AM_PC};
    endcase
  end
endmodule

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int IW = 9,
  parameter int OW = 16
) (
  input  logic [IW-1:0] val_i,
  output logic [OW-1:0] val_o
);
  localparam int EXT = OW - IW;
  generate
    if (EXT > 0) begin : g_ext
      assign val_o = {{EXT{val_i[IW-1]}}, val_i};
    end else begin : g_trunc
      assign val_o = val_i[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int DW = 16
) (
  input  amode_e                amode_i,
  input  logic [OFF_PC_W-1:0]   off_pc_i,
  input  logic [OFF_BASE_W-1:0] off_base_i,
  input  logic [DW-1:0]         npc_i,
  input  logic [DW-1:0]         base_i,
  output logic [DW-1:0]         ea_o
);
  logic [DW-1:0] ext_pc, ext_base;

  ea_sext #(.IW(OFF_PC_W), .OW(DW)) u_sext_pc (
    .val_i(off_pc_i), .val_o(ext_pc));
  ea_sext #(.IW(OFF_BASE_W), .OW(DW)) u_sext_base (
    .val_i(off_base_i), .val_o(ext_base));

  // single adder, operands muxed by mode; wraps modulo 2^DW
  logic use_base;
  assign use_base = (amode_i == AM_BASE);
  assign ea_o = (use_base ? base_i : npc_i) + (use_base ? ext_base : ext_pc);
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [DW-1:0]   npc_i,
  input  dec_t            dec_i,
  input  logic [DW-1:0]   ea_i,
  input  logic [DW-1:0]   src_i,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [ILEN-1:0] ir_o,
  output logic [DW-1:0]   npc_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic [2:0]      flags_o,
  output logic            done_o
);
  state_e state_q;
  logic [2:0] flags_q;

  function automatic logic [2:0] nzp(input logic [DW-1:0] d);
    nzp = {d[DW-1], d == '0, !d[DW-1] && (d != '0)};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ir_o        <= '0;
      npc_o       <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rf_we_o     <= 1'b0;
      rf_waddr_o  <= '0;
      rf_wdata_o  <= '0;
      flags_q     <= 3'b010;
      done_o      <= 1'b0;
    end else begin
      rf_we_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ir_o    <= instr_i;
          npc_o   <= npc_i;
          state_q <= S_CALC;
        end
        S_CALC: begin
          unique case (dec_i.kind)
            K_ADDR: begin
              rf_we_o    <= 1'b1;
              rf_waddr_o <= ir_o[DR_LSB +: RAW];
              rf_wdata_o <= ea_i;
              done_o     <= 1'b1;
              state_q    <= S_IDLE;
            end
            K_LOAD, K_STORE: begin
              mem_req_o   <= 1'b1;
              mem_addr_o  <= ea_i;
              mem_wdata_o <= src_i;
              if (dec_i.amode == AM_IND) begin
                mem_we_o <= 1'b0;  // pointer fetch first
                state_q  <= S_PTR;
              end else begin
                mem_we_o <= (dec_i.kind == K_STORE);
                state_q  <= S_MEM;
              end
            end
            default: begin
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end
          endcase
        end
        S_PTR: if (mem_ready_i) begin
          mem_addr_o <= mem_rdata_i;
          mem_we_o   <= (dec_i.kind == K_STORE);
          state_q    <= S_MEM;
        end
        S_MEM: if (mem_ready_i) begin
          mem_req_o <= 1'b0;
          mem_we_o  <= 1'b0;
          done_o    <= 1'b1;
          if (dec_i.kind == K_LOAD) begin
            rf_we_o    <= 1'b1;
            rf_waddr_o <= ir_o[DR_LSB +: RAW];
            rf_wdata_o <= mem_rdata_i;
            flags_q    <= nzp(mem_rdata_i);
          end
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign flags_o = flags_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_flags_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_q) == 1);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_addr_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CALC && dec_i.kind == K_ADDR) |=> !mem_req_o && rf_we_o && done_o);

  p_ptr_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PTR) |-> mem_req_o && !mem_we_o);

  p_store_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MEM && mem_ready_i && dec_i.kind == K_STORE)
      |=> $stable(flags_q) && !rf_we_o);
endmodule

// File: rtl/ls_agen.sv
module ls_agen
  import ea_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RAW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [DW-1:0]   npc_i,
  output logic [RAW-1:0]  base_raddr_o,
  input  logic [DW-1:0]   base_rdata_i,
  output logic [RAW-1:0]  src_raddr_o,
  input  logic [DW-1:0]   src_rdata_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic [2:0]      flags_o,
  output logic            done_o
);
  logic [ILEN-1:0] ir_q;
  logic [DW-1:0]   npc_q, ea;
  dec_t            dec;

  assign base_raddr_o = ir_q[BASE_LSB +: RAW];
  assign src_raddr_o  = ir_q[DR_LSB +: RAW];

  ea_decode u_dec (
    .opc_i(ir_q[ILEN-1 -: OPC_W]),
    .dec_o(dec)
  );

  ea_calc #(.DW(DW)) u_calc (
    .amode_i   (dec.amode),
    .off_pc_i  (ir_q[OFF_PC_W-1:0]),
    .off_base_i(ir_q[OFF_BASE_W-1:0]),
    .npc_i     (npc_q),
    .base_i    (base_rdata_i),
    .ea_o      (ea)
  );

  ea_ctrl #(.DW(DW), .RAW(RAW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .instr_i    (instr_i),
    .npc_i      (npc_i),
    .dec_i      (dec),
    .ea_i       (ea),
    .src_i      (src_rdata_i),
    .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i),
    .ir_o       (ir_q),
    .npc_o      (npc_q),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .flags_o    (flags_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/ls_agen_tb.sv
`timescale 1ns/1ps
module ls_agen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] instr = '0, npc = '0;
  logic [2:0] base_ra, src_ra, rf_wa, flags;
  logic [15:0] base_rd, src_rd, maddr, mwdata, mrdata = '0, rf_wd;
  logic mreq, mwe, mready = 1'b0, rf_we, done;

  logic [15:0] regs [8];
  logic [15:0] mem [256];
  int lat = 0;
  int n_chk = 0, n_bad = 0;
  int acc_n = 0, wr_n = 0, done_n = 0, hold_err = 0, wcnt = 0;
  logic [15:0] acc_addr [8];
  logic        acc_we [8];
  logic [15:0] f_addr, f_wd, wr_data;
  logic        f_we;
  logic [2:0]  wr_addr;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign base_rd = regs[base_ra];
  assign src_rd  = regs[src_ra];

  ls_agen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .npc_i(npc),
    .base_raddr_o(base_ra), .base_rdata_i(base_rd),
    .src_raddr_o(src_ra), .src_rdata_i(src_rd),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ready_i(mready), .mem_rdata_i(mrdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_wa), .rf_wdata_o(rf_wd),
    .flags_o(flags), .done_o(done)
  );

  // memory model with programmable wait states
  always @(negedge clk) begin
    if (!rst_n || !mreq) begin
      mready = 1'b0;
      wcnt = 0;
    end else begin
      if (mready) wcnt = 0;
      if (wcnt == 0) begin
        f_addr = maddr; f_we = mwe; f_wd = mwdata;
      end else if (maddr != f_addr || mwe != f_we || mwdata != f_wd) begin
        hold_err++;
      end
      if (wcnt >= lat) begin
        mready = 1'b1;
        mrdata = mem[maddr[7:0]];
        if (mwe) mem[maddr[7:0]] = mwdata;
        acc_addr[acc_n % 8] = maddr;
        acc_we[acc_n % 8] = mwe;
        acc_n++;
      end else begin
        mready = 1'b0;
        wcnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rf_we) begin wr_n++; wr_addr = rf_wa; wr_data = rf_wd; end
    if (done) done_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] i9(input logic [3:0] op, input logic [2:0] r, input logic [8:0] o);
    return {op, r, o};
  endfunction
  function automatic logic [15:0] i6(input logic [3:0] op, input logic [2:0] r, input logic [2:0] b, input logic [5:0] o);
    return {op, r, b, o};
  endfunction

  task automatic run(input logic [15:0] ins, input logic [15:0] pc, output int cyc,
                     input bit twice = 0, input logic [15:0] ins2 = '0);
    acc_n = 0; wr_n = 0; done_n = 0; hold_err = 0;
    @(negedge clk); start = 1'b1; instr = ins; npc = pc;
    @(negedge clk);
    if (twice) begin instr = ins2; @(negedge clk); end
    start = 1'b0; instr = '0;
    cyc = twice ? 2 : 1;
    while (done_n == 0 && cyc < 60) begin @(negedge clk); #1; cyc++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req", mreq, 0);
    chk("R1 done", done, 0);
    chk("R1 rf_we", rf_we, 0);
    chk("R1 flags", flags, 3'b010);
  endtask

  task automatic t_ld;
    int c;
    lat = 0; mem[8'h04] = 16'h1234;
    run(i9(4'b0010, 3'd2, 9'h1FF), 16'h3005, c);
    chk("R2 addr", acc_addr[0], 16'h3004);
    chk("R2 acc", acc_n, 1);
    chk("R2 we", acc_we[0], 0);
    chk("R2 wa", wr_addr, 2);
    chk("R2 wd", wr_data, 16'h1234);
    chk("R2 cyc", c, 3);
    chk("R8 pos", flags, 3'b001);
    chk("R11 once", done_n, 1);
  endtask

  task automatic t_ldr;
    int c;
    lat = 2; regs[5] = 16'h1010; mem[8'h0E] = 16'h0000;
    run(i6(4'b0110, 3'd6, 3'd5, 6'h3E), 16'h0000, c);
    chk("R3 addr", acc_addr[0], 16'h100E);
    chk("R3 wa", wr_addr, 6);
    chk("R3 wd", wr_data, 0);
    chk("R8 zero", flags, 3'b010);
    chk("R9 hold", hold_err, 0);
    chk("R9 cyc", c, 5);
  endtask

  task automatic t_ldi;
    int c;
    lat = 0; mem[8'h10] = 16'h0055; mem[8'h55] = 16'h8001;
    run(i9(4'b1010, 3'd1, 9'h010), 16'h2000, c);
    chk("R4 n", acc_n, 2);
    chk("R4 ptr", acc_addr[0], 16'h2010);
    chk("R4 data", acc_addr[1], 16'h0055);
    chk("R4 rd", {acc_we[0], acc_we[1]}, 0);
    chk("R4 wd", wr_data, 16'h8001);
    chk("R4 cyc", c, 4);
    chk("R8 neg", flags, 3'b100);
  endtask

  task automatic t_st;
    int c; logic [2:0] f0;
    lat = 1; regs[3] = 16'hBEEF; f0 = flags;
    run(i9(4'b0011, 3'd3, 9'h0A5), 16'h1000, c);
    chk("R5 addr", acc_addr[0], 16'h10A5);
    chk("R5 we", acc_we[0], 1);
    chk("R5 mem", mem[8'hA5], 16'hBEEF);
    chk("R5 no rf", wr_n, 0);
    chk("R5 flags", flags, f0);
    regs[4] = 16'h0102; regs[7] = 16'h5A5A;
    run(i6(4'b0111, 3'd7, 3'd4, 6'h1F), 16'h0000, c);
    chk("R5 str addr", acc_addr[0], 16'h0121);
    chk("R5 str mem", mem[8'h21], 16'h5A5A);
    chk("R5 str flags", flags, f0);
    chk("R11 store done", done_n, 1);
  endtask

  task automatic t_sti;
    int c;
    lat = 2; mem[8'h20] = 16'h0077; mem[8'h77] = 16'h0;
    run(i9(4'b1011, 3'd3, 9'h020), 16'h4000, c);
    chk("R6 n", acc_n, 2);
    chk("R6 ptr", acc_addr[0], 16'h4020);
    chk("R6 ptr rd", acc_we[0], 0);
    chk("R6 dst", acc_addr[1], 16'h0077);
    chk("R6 dst wr", acc_we[1], 1);
    chk("R6 mem", mem[8'h77], 16'hBEEF);
    chk("R6 no rf", wr_n, 0);
    chk("R9 hold sti", hold_err, 0);
  endtask

  task automatic t_lea;
    int c; logic [2:0] f0;
    f0 = flags;
    run(i9(4'b1110, 3'd0, 9'h100), 16'h0050, c);
    chk("R7 wd", wr_data, 16'hFF50);
    chk("R7 wa", wr_addr, 0);
    chk("R7 nomem", acc_n, 0);
    chk("R7 cyc", c, 2);
    chk("R7 flags", flags, f0);
  endtask

  task automatic t_wrap;
    int c;
    lat = 0; mem[8'hEF] = 16'h7FFF;
    run(i9(4'b0010, 3'd4, 9'h0FF), 16'hFFF0, c);
    chk("R12 addr", acc_addr[0], 16'h00EF);
    chk("R8 pos2", flags, 3'b001);
  endtask

  task automatic t_busy;
    int c;
    lat = 3; mem[8'h04] = 16'h0042;
    run(i9(4'b0010, 3'd2, 9'h1FF), 16'h3005, c, 1, i9(4'b1110, 3'd5, 9'h001));
    chk("R10 one wr", wr_n, 1);
    chk("R10 wa", wr_addr, 2);
    chk("R10 acc", acc_n, 1);
    chk("R9 hold3", hold_err, 0);
    run(16'h1283, 16'h0100, c);
    chk("R10 other cyc", c, 2);
    chk("R10 other acc", acc_n, 0);
    chk("R10 other wr", wr_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h0101);
    for (int i = 0; i < 256; i++) mem[i] = 16'(i);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ld; t_ldr; t_ldi; t_st; t_sti; t_lea; t_wrap; t_busy;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule